// File: doc/BRIEF.md
# Coherency control register window

This block is the register front of a multiprocessor coherency controller. It occupies a 256-byte window at the base of the processors' private peripheral space. A simple word bus reaches it, with one address, a write strobe with its data, and a read strobe whose data comes back one cycle later. Only the register view is modelled. No snooping, coherency or cache maintenance takes place behind it.

The window holds four word registers on aligned offsets:
- a single-bit enable at 0x00;
- a read-only topology word at 0x04, derived from the number of cores;
- a status word at 0x08 that always reads zero;
- a cache-flush trigger at 0x0C, which accepts writes and does nothing with them.

Every other offset, including an unaligned byte offset, is undefined. Software that touches an undefined offset, or writes a read-only register, gets a one-cycle error pulse. Such an access has no other effect.

Top module: `coh_ctrl_regs`

## Requirements
- R1: After reset the enable bit is 0, `rd_data` is 0 and `err` is low.
- R2: A write to offset 0x00 stores bit 0 of `wr_data` and drops the other bits. A read of 0x00 returns the stored bit in bit 0, with all other bits zero.
- R3: A read of offset 0x04 returns `((1<<NCORES)-1)<<4 | (NCORES-1)`, with `NCORES` in 1..4. A write to 0x04 changes nothing and raises `err`.
- R4: A read of offset 0x08 returns 0. A write to 0x08 changes nothing and raises `err`.
- R5: A read of offset 0x0C returns 0. A write to 0x0C is accepted without `err` and leaves the enable bit unchanged.
- R6: A read of any other byte offset returns 0 and raises `err`. Such offsets include 0x10..0xFF and any offset with bits 1:0 non-zero. A write to such an offset leaves the enable bit unchanged and raises `err`.
- R7: `rd_data` is registered. It shows the value for the address presented with `rd_en` in the cycle after that strobe, and it is 0 in any cycle that follows one without `rd_en`.
- R8: `err` is combinational from the bus inputs. It is high only in the cycle of an offending access, and it is low for every legal access and every idle cycle.
- R9: If a read and a write of 0x00 arrive in the same cycle, the read returns the enable value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW (8) | Byte offset within the window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW (32) | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW (32) | Read data, one cycle after `rd_en` |
| err | output | 1 | Error pulse for an access to an undefined or read-only offset |

## Verification
The bound checker checks the following on every cycle:
- the error pulse against the offset class of each access;
- the topology word and the zero-reading registers one cycle after their reads;
- zero read data after idle cycles;
- that the enable bit moves only on a write to 0x00.

The stored value itself can only be shown through the bench's sequences. These sequences cover write-then-read of both bit values, ignored writes followed by read-back, and a read that collides with a write of the enable bit. The bench's behavioural model is compared against both outputs on every clock.

// File: rtl/coh_ctrl_regs.sv
module coh_ctrl_regs #(
  parameter int NCORES = 1,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          err
);
  localparam logic [7:0] PRESENT = 8'(((1 << NCORES) - 1) << 4);
  localparam logic [7:0] TOPO = PRESENT | 8'(NCORES - 1);

  initial begin
    if (NCORES < 1 || NCORES > 4) $error("NCORES must lie in 1..4");
  end

  logic ctrl_q;

  wire aligned = (addr[1:0] == 2'b00) && (addr[AW-1:4] == '0);
  wire [1:0] word = addr[3:2];
  wire rd_ok = aligned;
  wire wr_ok = aligned && (word == 2'd0 || word == 2'd3);

  assign err = (rd_en && !rd_ok) || (wr_en && !wr_ok);

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (word)
        2'd0: rd_mux = DW'(ctrl_q);
        2'd1: rd_mux = DW'(TOPO);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_data <= rd_en ? rd_mux : '0;
      if (wr_en && aligned && word == 2'd0) ctrl_q <= wr_data[0];
    end
  end
endmodule

module coh_ctrl_regs_chk #(
  parameter int NCORES = 1,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          err,
  input logic          ctrl_q
);
  function automatic logic [DW-1:0] topo_f();
    logic [DW-1:0] v;
    v = DW'(NCORES - 1);
    for (int i = 0; i < NCORES; i++) v[4+i] = 1'b1;
    return v;
  endfunction

  wire legal_rd = (addr < AW'(16)) && (addr[1:0] == 2'b00);
  wire legal_wr = (addr == AW'(0)) || (addr == AW'(12));

  a_r3_topology: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == AW'(4) |=> rd_data == topo_f());
  a_r4_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == AW'(8) |=> rd_data == '0);
  a_r5_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == AW'(12) |=> rd_data == '0);
  a_r6_bad_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !legal_rd) || (wr_en && !legal_wr) |-> err);
  a_r8_good_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || legal_rd) && (!wr_en || legal_wr) |-> !err);
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == '0);
  a_r2_enable_moves: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(0)) |=> $stable(ctrl_q));
  a_r2_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DW-1:8] == '0);
endmodule

bind coh_ctrl_regs coh_ctrl_regs_chk #(.NCORES(NCORES), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .err(err), .ctrl_q(ctrl_q)
);

// File: tb/sim_coh_ctrl_regs.sv
module sim_coh_ctrl_regs;
  localparam int N = 3;
  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic err;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  coh_ctrl_regs #(.NCORES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .err(err)
  );

  int m_ctrl = 0;
  logic [31:0] m_rd = 0;
  string m_tag = "R1";

  function automatic logic [31:0] topo();
    int v = N - 1;
    for (int i = 0; i < N; i++) v += (1 << (4 + i));
    return v;
  endfunction

  function automatic bit known(input logic [7:0] a);
    return a == 0 || a == 4 || a == 8 || a == 12;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04: return "R3";
      8'h08: return "R4";
      8'h0C: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_rd = 0; m_tag = "R1";
    end else begin
      if (rd_en) begin
        m_rd = (addr == 0) ? m_ctrl : (addr == 4) ? topo() : 0;
        m_tag = (addr == 0 && wr_en) ? "R9" : tag_of(addr);
      end else begin
        m_rd = 0; m_tag = "R7";
      end
      if (wr_en && addr == 0) m_ctrl = wr_data[0];
    end
  end

  always @(negedge clk) begin
    chk(m_tag, rd_data, m_rd);
    #1;
    if (!rst_n) chk("R1", {31'b0, err}, 0);
    else chk((rd_en || wr_en) ? "R8" : "R8 idle", {31'b0, err},
             {31'b0, (rd_en && !known(addr)) ||
                     (wr_en && !(addr == 0 || addr == 12))});
  end

  task automatic acc(input logic [7:0] a, input bit w, input logic [31:0] d, input bit r);
    @(negedge clk);
    addr = a; wr_en = w; wr_data = d; rd_en = r;
  endtask

  task automatic idle();
    acc(0, 0, 0, 0);
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    acc(8'h00, 0, 0, 1);           // R1 enable reads 0 after reset
    acc(8'h04, 0, 0, 1);           // R3 topology
    acc(8'h00, 1, 32'hFFFF_FFFF, 0); // R2 only bit 0 kept
    acc(8'h00, 0, 0, 1);
    acc(8'h00, 1, 32'hFFFF_FFFE, 0);
    acc(8'h00, 0, 0, 1);
    acc(8'h00, 1, 32'h1, 0);
    acc(8'h04, 1, 32'h0, 0);       // R3 ignored write
    acc(8'h08, 1, 32'h0, 0);       // R4 ignored write
    acc(8'h0C, 1, 32'h0, 0);       // R5 accepted, no effect
    acc(8'h00, 0, 0, 1);
    acc(8'h08, 0, 0, 1);           // R4
    acc(8'h0C, 0, 0, 1);           // R5
    acc(8'h10, 1, 32'h0, 0);       // R6 out of range write
    acc(8'h02, 1, 32'h0, 0);       // R6 unaligned write
    acc(8'hFC, 1, 32'h0, 0);
    acc(8'h00, 0, 0, 1);           // enable still 1
    acc(8'h10, 0, 0, 1);           // R6 reads
    acc(8'h05, 0, 0, 1);
    acc(8'hFF, 0, 0, 1);
    idle(); idle();                // R7
    acc(8'h00, 1, 32'h0, 1);       // R9 read sees old value 1
    acc(8'h00, 1, 32'h1, 1);       // R9 read sees old value 0
    acc(8'h00, 0, 0, 1);
    acc(8'h04, 1, 32'h0, 1);       // read ok, write bad
    for (int i = 0; i < 64; i++) acc(8'(i * 7), i[0], 32'(i), i[1]);
    idle(); idle();
    @(negedge clk); #2;
    finish_up();
  end
endmodule